// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block sits between a synchronous host and a byte-wide asynchronous static RAM of 2^19 words. The host hands it one word-sized read or write at a time over a valid/ready request channel. The controller then drives the memory's address lines, its three active-low strobes (chip select, write strobe and output enable) and a data bus that the controller drives only during writes. A read result returns to the host as a single-cycle response pulse.

Every analog timing limit of the memory is a nanosecond parameter. The controller turns each one into a clock count, rounding up against the clock-period parameter, so one netlist serves both the faster and the slower speed grade. Three intervals are counted separately: the access window of a read, the time the memory needs to let go of the bus after a read, and the write pulse with its setup and hold cycles.

A level-sensitive retention input lets the host park the memory deselected in its low-power state. Once the input drops, the controller waits one full cycle-time before it takes new work.

Back-pressure rules:
- A request transfers on a rising clock edge where `req_valid` and `req_ready` are both high.
- While `req_valid` is high and `req_ready` is low, the host holds the request fields steady.
- Responses carry no back-pressure, so the host must take `rsp_valid` whenever it pulses.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held, the chip select, write strobe and output enable outputs are all high, the data-drive enable and `rsp_valid` are low. After reset, with retention not requested, `req_ready` is high.
- R2: An accepted read keeps chip select and output enable low, the write strobe high, the data-drive enable low and the address equal to the request address for exactly ceil(max(cycle time, OE access)/period) cycles. At the defaults (5 ns clock, 70 ns and 35 ns) this is 14 cycles.
- R3: `rsp_valid` is high for exactly one cycle, the cycle right after the last read cycle. `rsp_rdata` equals the memory data present in that last cycle, before the address moves.
- R4: An accepted write has three phases, all with chip select low, output enable high, the data-drive enable high and address and data steady. First comes one setup cycle with the write strobe high. Then the write strobe stays low for ceil(cycle time/period) cycles (14 at defaults). Last comes one hold cycle with the write strobe high. `req_ready` returns high 17 cycles after acceptance at defaults.
- R5: After a read, chip select and output enable are high and `req_ready` stays low for ceil(max(OE release, CE release)/period) cycles (7 at defaults) before any new access. The data-drive enable is never high while output enable is low.
- R6: `req_ready` is high only when no access or wait is in progress, and then chip select is high and the bus is not driven. A write produces no response pulse.
- R7: While `sleep_req` is high, `req_ready` is low. Once the controller is between accesses, chip select stays high. A `sleep_req` that rises during an access lets that access finish normally, including its response.
- R8: After `sleep_req` falls in retention, `req_ready` rises on the (ceil(cycle time/period)+1)-th rising edge counted from the first edge that sees it low. At defaults that is the 15th edge.
- R9: When `sleep_req` and `req_valid` rise in the same cycle, retention wins and the request is not accepted. The request stays pending and is accepted on the first edge after recovery ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 8 | Read result |
| sleep_req | input | 1 | Level request for deselected retention |
| mem_addr | output | 19 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the tri-state data pads |
| mem_dq_in | input | 8 | Data received from the memory pads |

## Verification
Retention entry can land in the same cycle as a host request, and it can also land in the middle of an access already under way. The bench raises `sleep_req` together with `req_valid` from idle. It judges by watching chip select and `req_ready`, and it times when the still-pending request is finally accepted after recovery. It also raises retention partway through a read and expects the full access window and a correct response before the controller parks. The memory model in the bench returns valid data only once the read has been active for the access count, so any early sample shows up as a wrong byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RETAIN,
    ST_RECOVER
  } ctrl_state_e;

  function automatic int cyc_ceil(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CW    = 4,
  parameter int N_ACC = 14,
  parameter int N_CYC = 14,
  parameter int N_REL = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          sleep_req,
  input  logic          ph_busy,
  input  logic          rel_busy,
  output logic          req_ready,
  output logic          accept,
  output logic          rd_done,
  output logic          ph_load,
  output logic [CW-1:0] ph_val,
  output logic          rel_load,
  output logic [CW-1:0] rel_val,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe
);

  ctrl_state_e state_q, state_d;

  // the host may only start work from idle, outside retention, bus released
  assign req_ready = (state_q == ST_IDLE) && !sleep_req && !rel_busy;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d  = state_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    rel_load = 1'b0;
    rel_val  = CW'(N_REL);
    rd_done  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (sleep_req) begin
          state_d = ST_RETAIN;
        end else if (accept) begin
          ph_load = 1'b1;
          if (req_write) begin
            state_d = ST_WSETUP;
            ph_val  = '0;
          end else begin
            state_d = ST_READ;
            ph_val  = CW'(N_ACC - 1);
          end
        end
      end
      ST_READ: begin
        if (!ph_busy) begin
          state_d  = ST_IDLE;
          rd_done  = 1'b1;
          rel_load = 1'b1;
        end
      end
      ST_WSETUP: begin
        state_d = ST_WPULSE;
        ph_load = 1'b1;
        ph_val  = CW'(N_CYC - 1);
      end
      ST_WPULSE: begin
        if (!ph_busy) state_d = ST_WHOLD;
      end
      ST_WHOLD: begin
        state_d = ST_IDLE;
      end
      ST_RETAIN: begin
        if (!sleep_req) begin
          state_d = ST_RECOVER;
          ph_load = 1'b1;
          ph_val  = CW'(N_CYC - 1);
        end
      end
      ST_RECOVER: begin
        if (!ph_busy) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // strobes decode straight from the state register
  always_comb begin
    ce_n  = 1'b1;
    we_n  = 1'b1;
    oe_n  = 1'b1;
    dq_oe = 1'b0;
    case (state_q)
      ST_READ: begin
        ce_n = 1'b0;
        oe_n = 1'b0;
      end
      ST_WSETUP, ST_WHOLD: begin
        ce_n  = 1'b0;
        dq_oe = 1'b1;
      end
      ST_WPULSE: begin
        ce_n  = 1'b0;
        we_n  = 1'b0;
        dq_oe = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  // address and write data move only on acceptance, so they stay put
  // through every phase of an access and through the release wait
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_done;
      if (rd_done) rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_CYCLE_NS    = 70,
  parameter int T_OE_ACC_NS   = 35,
  parameter int T_OE_REL_NS   = 30,
  parameter int T_CE_REL_NS   = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              sleep_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int N_CYC = imax(1, cyc_ceil(T_CYCLE_NS, CLK_PERIOD_NS));
  localparam int N_OEA = cyc_ceil(T_OE_ACC_NS, CLK_PERIOD_NS);
  localparam int N_ACC = imax(N_CYC, N_OEA);
  localparam int N_REL = imax(1, imax(cyc_ceil(T_OE_REL_NS, CLK_PERIOD_NS),
                                      cyc_ceil(T_CE_REL_NS, CLK_PERIOD_NS)));
  localparam int N_MAX = imax(N_ACC, N_REL);
  localparam int CW    = $clog2(N_MAX + 1);

  logic          accept, rd_done;
  logic          ph_load, ph_busy, rel_load, rel_busy;
  logic [CW-1:0] ph_val, rel_val;

  sram_ctrl_seq #(
    .CW(CW), .N_ACC(N_ACC), .N_CYC(N_CYC), .N_REL(N_REL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .sleep_req(sleep_req),
    .ph_busy(ph_busy), .rel_busy(rel_busy),
    .req_ready(req_ready), .accept(accept), .rd_done(rd_done),
    .ph_load(ph_load), .ph_val(ph_val),
    .rel_load(rel_load), .rel_val(rel_val),
    .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
  );

  // phase timer paces access/pulse/recovery, release timer guards the bus
  sram_ctrl_timer #(.CW(CW)) u_phase_tmr (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .busy(ph_busy)
  );

  sram_ctrl_timer #(.CW(CW)) u_release_tmr (
    .clk(clk), .rst_n(rst_n), .load(rel_load), .load_val(rel_val), .busy(rel_busy)
  );

  sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_done(rd_done),
    .mem_dq_in(mem_dq_in), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_req,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  // R4: the write strobe only falls inside a selected, driven, output-off cycle
  a_r4_strobe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe && mem_oe_n));

  // R4: a setup cycle with the bus driven precedes the strobe
  a_r4_setup_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_dq_oe) && !$past(mem_ce_n)));

  // R4: a hold cycle follows the strobe
  a_r4_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

  // R2/R4: address frozen while the memory stays selected
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R5: never drive while the memory drives
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R3: response is a single-cycle pulse
  a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6: ready implies a quiet memory interface
  a_r6_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_dq_oe));

  // R7: retention request blocks new work
  a_r7_retain_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> !req_ready);

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  localparam int PER   = 5;
  localparam int TCYC  = (70 + PER - 1) / PER;
  localparam int TOEA  = (35 + PER - 1) / PER;
  localparam int TACC  = (TCYC > TOEA) ? TCYC : TOEA;
  localparam int TREL  = (35 + PER - 1) / PER;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, sleep_req = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int n_chk = 0, n_fail = 0, n_contend = 0, rd_age = 0;
  logic [7:0]  model_mem [256];
  logic [7:0]  exp_mem   [256];
  logic [18:0] pool [8];

  always #2.5 clk = ~clk;

  sram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sleep_req(sleep_req),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  function automatic logic [7:0] init_byte(input int idx);
    return 8'(idx * 37 + 5);
  endfunction

  // memory model: data valid only once the read has run for the access count
  wire rd_active = !mem_ce_n && !mem_oe_n && mem_we_n;
  always @(posedge clk) rd_age <= rd_active ? rd_age + 1 : 0;
  assign mem_dq_in = (rd_active && rd_age >= TACC - 1) ? model_mem[mem_addr[7:0]] : 8'hEE;
  always @(posedge mem_we_n) if (!mem_ce_n && mem_dq_oe) model_mem[mem_addr[7:0]] <= mem_dq_out;
  always @(negedge clk) if (rst_n && mem_dq_oe && !mem_oe_n) n_contend++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) exp_mem[a[7:0]] = d;
  endtask

  task automatic do_read(input logic [18:0] a);
    int n, k;
    issue(1'b0, a, 8'h00);
    n = 1;
    while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
    check(n == TACC + 1, "R3 response cycle", n, TACC + 1);
    check(rsp_rdata == exp_mem[a[7:0]], "R3 read data", rsp_rdata, exp_mem[a[7:0]]);
    k = 0;
    while (!req_ready && k < 60) begin @(negedge clk); k++; end
    check(k == TREL, "R5 release wait", k, TREL);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int n;
    issue(1'b1, a, d);
    n = 1;
    while (!req_ready && n < 60) begin
      if (rsp_valid) check(1'b0, "R6 response after write", 1, 0);
      @(negedge clk); n++;
    end
    check(n == TCYC + 3, "R4 write length", n, TCYC + 3);
  endtask

  task automatic do_sleep(input int hold);
    int n;
    @(negedge clk); sleep_req = 1'b1; #1;
    check(!req_ready, "R7 ready drop", req_ready, 0);
    repeat (hold) @(negedge clk);
    check(mem_ce_n && !req_ready, "R7 parked", {mem_ce_n, req_ready}, 2);
    sleep_req = 1'b0;
    n = 0;
    do begin @(posedge clk); @(negedge clk); n++; end while (!req_ready && n < 60);
    check(n == TCYC + 1, "R8 recovery", n, TCYC + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lows, n;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      model_mem[i] = init_byte(i);
      exp_mem[i]   = init_byte(i);
    end
    pool[0] = 19'h00000;
    pool[7] = 19'h7FFFF;
    for (int i = 1; i < 7; i++) pool[i] = {$urandom_range(2047, 0) & 11'h7FF, 5'($urandom), 3'(i)};

    // R1 reset state
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    check(!mem_dq_oe && !rsp_valid, "R1 bus and response in reset", {mem_dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", req_ready, 1);

    // R2 directed read window on the lowest address
    issue(1'b0, pool[0], 8'h00);
    lows = 0;
    while (!mem_ce_n && lows < 60) begin
      if (mem_oe_n || !mem_we_n || mem_dq_oe || mem_addr != pool[0])
        check(1'b0, "R2 read strobes", {mem_oe_n, mem_we_n, mem_dq_oe}, 4);
      lows++;
      @(negedge clk);
    end
    check(lows == TACC, "R2 read window", lows, TACC);
    check(rsp_valid && rsp_rdata == exp_mem[0], "R3 directed data", rsp_rdata, exp_mem[0]);
    @(negedge clk);
    check(!rsp_valid, "R3 single pulse", rsp_valid, 0);
    while (!req_ready) @(negedge clk);

    // R4 directed write on the highest address
    issue(1'b1, pool[7], 8'hA5);
    check(!mem_ce_n && mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_out == 8'hA5,
          "R4 setup cycle", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 7);
    @(negedge clk);
    lows = 0;
    while (!mem_we_n && lows < 60) begin
      if (mem_addr != pool[7] || mem_dq_out != 8'hA5) check(1'b0, "R4 stable", mem_dq_out, 8'hA5);
      lows++;
      @(negedge clk);
    end
    check(lows == TCYC, "R4 strobe width", lows, TCYC);
    check(!mem_ce_n && mem_dq_oe && mem_addr == pool[7], "R4 hold cycle", {mem_ce_n, mem_dq_oe}, 1);
    @(negedge clk);
    check(req_ready && mem_ce_n, "R6 ready after write", req_ready, 1);
    do_read(pool[7]);

    // R5 read then write back-to-back: write must wait out the release
    do_read(pool[3]);
    do_write(pool[3], 8'h3C);
    do_read(pool[3]);

    // R9 retention and request raised in the same cycle
    @(negedge clk);
    sleep_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = pool[5];
    repeat (4) begin
      @(negedge clk);
      check(mem_ce_n && !req_ready, "R9 retention wins", {mem_ce_n, req_ready}, 2);
    end
    sleep_req = 1'b0;
    n = 0;
    do begin @(posedge clk); @(negedge clk); n++; end while (mem_ce_n && n < 60);
    check(n == TCYC + 2, "R9 pending request accepted", n, TCYC + 2);
    req_valid = 1'b0;
    lows = 1;
    while (!rsp_valid && lows < 60) begin @(negedge clk); lows++; end
    check(rsp_rdata == exp_mem[pool[5][7:0]], "R9 served data", rsp_rdata, exp_mem[pool[5][7:0]]);
    while (!req_ready) @(negedge clk);

    // R7 retention raised in the middle of a read
    issue(1'b0, pool[7], 8'h00);
    repeat (4) @(negedge clk);
    sleep_req = 1'b1;
    n = 5;
    while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
    check(n == TACC + 1, "R7 access completes", n, TACC + 1);
    check(rsp_rdata == exp_mem[pool[7][7:0]], "R7 data intact", rsp_rdata, exp_mem[pool[7][7:0]]);
    repeat (3) @(negedge clk);
    check(mem_ce_n && !req_ready, "R7 parked after access", {mem_ce_n, req_ready}, 2);
    sleep_req = 1'b0;
    n = 0;
    do begin @(posedge clk); @(negedge clk); n++; end while (!req_ready && n < 60);
    check(n == TCYC + 1, "R8 recovery after mid-access entry", n, TCYC + 1);

    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      int sel;
      sel = $urandom_range(99, 0);
      if (sel < 45) do_write(pool[$urandom_range(7, 0)], 8'($urandom));
      else if (sel < 90) do_read(pool[$urandom_range(7, 0)]);
      else do_sleep($urandom_range(6, 2));
    end

    check(n_contend == 0, "R5 no bus contention", n_contend, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule